// File: doc/BRIEF.md
# Single-Cycle Load/Store CPU Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. The program counter selects a word from a small internal instruction store. A main decoder turns the opcode into control signals. A second decoder combines the decoder's ALU class with the function field to choose the ALU operation. Operands come from a 32-entry register file. The ALU result is written to a register, or it forms an address into a small internal data store. The core handles three register-register logic and arithmetic operations plus subtraction, a word load, a word store, and a branch-if-equal.

While reset is held, the core does not execute. During that time a loader port writes the instruction store, the data store and the register file, one word per clock. After reset is released, execution starts at address zero. The current ALU result, the PC, register 0 and one selectable data word are visible on output ports so that a bench can follow execution.

Top module: `sc_cpu_core`

## Requirements
- R1: While `rst` is high the PC is 0 and no instruction writes state. Each clock with `ld_sel` = 1, 2 or 3 writes `ld_data` to instruction word, data word or register `ld_addr` respectively.
- R2: After any instruction other than a taken branch, the PC increases by 4.
- R3: A taken branch-if-equal (opcode 0x04 in bits 31:26) sets the PC to its own PC plus the sign-extended 16-bit immediate (bits 15:0) times 4.
- R4: Branch-if-equal subtracts register rt (bits 20:16) from register rs (bits 25:21) and shows the difference on `alu_result`. The branch is taken exactly when that difference is zero, and it writes no register or data word.
- R5: Opcode 0 with function field (bits 5:0) 0x24, 0x25, 0x20 or 0x22 computes rs AND rt, rs OR rt, rs+rt or rs−rt respectively. The result is written to register rd (bits 15:11).
- R6: Store (opcode 0x2B) writes register rt to data word (rs + sign-extended immediate) modulo the store depth. `alu_result` shows the effective address, and no register is written.
- R7: Load (opcode 0x23) writes data word (rs + sign-extended immediate) modulo the store depth into register rt. `alu_result` shows the effective address.
- R8: The instruction executed is instruction word PC[7:2]. The PC therefore wraps modulo 256 bytes with the default 64-word store.
- R9: `mem_word` always shows data word `obs_addr`, including writes made by earlier instructions.
- R10: Register 0 is an ordinary writable register, and `reg0` always shows its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the loader |
| ld_sel | input | 2 | Loader target: 0 none, 1 instruction, 2 data, 3 register |
| ld_addr | input | LD_AW | Loader word or register index |
| ld_data | input | XLEN | Loader write data |
| obs_addr | input | $clog2(DMEM_WORDS) | Data word shown on `mem_word` |
| pc | output | XLEN | Current program counter |
| alu_result | output | XLEN | ALU output of the current instruction |
| mem_word | output | XLEN | Data word at `obs_addr` |
| reg0 | output | XLEN | Contents of register 0 |

## Verification
On every cycle, the assertions check the PC sequencing after non-branching and taken-branch instructions, the match between the ALU zero flag and operand equality on branches, the exclusion between register and store writes, and the landing of each write in its target array. The data values that the ALU computes, the effects of load-after-store ordering, loops created by backward branches and PC wrap only show up in the bench. There, a reference model runs the same directed and random programs and compares the visible outputs after every instruction.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BEQ   = 6'h04;

   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FUNCT = 2'b10,
      CLS_NONE  = 2'b11
   } alu_class_e;

   typedef enum logic [1:0] {
      FN_SEL_AND = 2'd0,
      FN_SEL_OR  = 2'd1,
      FN_SEL_ADD = 2'd2,
      FN_SEL_SUB = 2'd3
   } alu_fn_e;

   typedef struct packed {
      logic       dst_rd;
      logic       src_imm;
      logic       wb_mem;
      logic       reg_wr;
      logic       mem_rd;
      logic       mem_wr;
      logic       branch;
      alu_class_e alu_cls;
   } ctrl_t;
endpackage

// File: rtl/cpu_main_ctrl.sv
module cpu_main_ctrl
   import cpu_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '0;
      ctl.alu_cls = CLS_NONE;
      case (opcode)
         OPC_RTYPE: begin
            ctl.dst_rd  = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.alu_cls = CLS_FUNCT;
         end
         OPC_LOAD: begin
            ctl.src_imm = 1'b1;
            ctl.wb_mem  = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.mem_rd  = 1'b1;
            ctl.alu_cls = CLS_ADD;
         end
         OPC_STORE: begin
            ctl.src_imm = 1'b1;
            ctl.mem_wr  = 1'b1;
            ctl.alu_cls = CLS_ADD;
         end
         OPC_BEQ: begin
            ctl.branch  = 1'b1;
            ctl.alu_cls = CLS_SUB;
         end
         default: ctl = '0;
      endcase
   end

   // R6: a store never also writes a register
   always_comb begin
      p_wr_excl_r6: assert (!(ctl.reg_wr && ctl.mem_wr))
         else $error("register and store write together");
   end
endmodule

// File: rtl/cpu_alu_ctrl.sv
module cpu_alu_ctrl
   import cpu_pkg::*;
(
   input  alu_class_e cls,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);
   always_comb begin
      case (cls)
         CLS_ADD: fn = FN_SEL_ADD;
         CLS_SUB: fn = FN_SEL_SUB;
         CLS_FUNCT: begin
            case (funct)
               FN_AND:  fn = FN_SEL_AND;
               FN_OR:   fn = FN_SEL_OR;
               FN_SUB:  fn = FN_SEL_SUB;
               default: fn = FN_SEL_ADD;
            endcase
         end
         default: fn = FN_SEL_ADD;
      endcase
   end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
   import cpu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_fn_e        fn,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y,
   output logic           zero
);
   always_comb begin
      case (fn)
         FN_SEL_AND: y = a & b;
         FN_SEL_OR:  y = a | b;
         FN_SEL_SUB: y = a - b;
         default:    y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32,
   localparam int RAW  = $clog2(NREGS)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           we,
   input  logic [RAW-1:0] wa,
   input  logic [W-1:0]   wd,
   input  logic [RAW-1:0] ra1,
   input  logic [RAW-1:0] ra2,
   output logic [W-1:0]   rd1,
   output logic [W-1:0]   rd2,
   output logic [W-1:0]   r0
);
   logic [W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (we && wa == RAW'(i)) regs[i] <= wd;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign r0  = regs[0];

   // R5/R7/R10: each write lands in its target register
   p_rf_write_r10: assert property (@(posedge clk) disable iff (rst)
      we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
   import cpu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter int LD_AW      = 6
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [1:0]                    ld_sel,
   input  logic [LD_AW-1:0]              ld_addr,
   input  logic [XLEN-1:0]               ld_data,
   input  logic [$clog2(DMEM_WORDS)-1:0] obs_addr,
   output logic [XLEN-1:0]               pc,
   output logic [XLEN-1:0]               alu_result,
   output logic [XLEN-1:0]               mem_word,
   output logic [XLEN-1:0]               reg0
);
   localparam int IM_AW = $clog2(IMEM_WORDS);
   localparam int DM_AW = $clog2(DMEM_WORDS);
   localparam int RAW   = $clog2(NREGS);
   localparam logic [1:0] LD_IMEM = 2'd1;
   localparam logic [1:0] LD_DMEM = 2'd2;
   localparam logic [1:0] LD_REG  = 2'd3;

   if (XLEN != 32) begin : g_bad_xlen
      $error("XLEN must be 32");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("NREGS must be 32 for 5-bit register fields");
   end
   if (LD_AW < IM_AW || LD_AW < DM_AW || LD_AW < RAW) begin : g_bad_ld
      $error("LD_AW too narrow");
   end
   if ((1 << IM_AW) != IMEM_WORDS || (1 << DM_AW) != DMEM_WORDS) begin : g_bad_depth
      $error("memory depths must be powers of two");
   end

   logic [XLEN-1:0] imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];

   logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, wb_data, rdata, pc_next;
   logic [5:0]      opcode, funct;
   logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wa;
   logic [DM_AW-1:0] dm_idx;
   ctrl_t           ctl;
   alu_fn_e         fn;
   logic            zero, take, rf_we, dm_we;
   logic [RAW-1:0]  rf_wa;
   logic [XLEN-1:0] rf_wd;

   // fetch and field split
   assign instr   = imem[pc[IM_AW+1:2]];
   assign opcode  = instr[31:26];
   assign rs_idx  = instr[25:21];
   assign rt_idx  = instr[20:16];
   assign rd_idx  = instr[15:11];
   assign funct   = instr[5:0];
   assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

   cpu_main_ctrl u_main (.opcode(opcode), .ctl(ctl));
   cpu_alu_ctrl  u_actl (.cls(ctl.alu_cls), .funct(funct), .fn(fn));

   assign wa    = ctl.dst_rd ? rd_idx : rt_idx;
   assign rf_we = rst ? (ld_sel == LD_REG) : ctl.reg_wr;
   assign rf_wa = rst ? ld_addr[RAW-1:0] : wa;
   assign rf_wd = rst ? ld_data : wb_data;

   cpu_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
      .ra1(rs_idx), .ra2(rt_idx), .rd1(rs_val), .rd2(rt_val), .r0(reg0)
   );

   assign alu_b = ctl.src_imm ? imm_ext : rt_val;

   cpu_alu #(.W(XLEN)) u_alu (
      .fn(fn), .a(rs_val), .b(alu_b), .y(alu_result), .zero(zero)
   );

   // data store
   assign dm_idx  = alu_result[DM_AW-1:0];
   assign rdata   = ctl.mem_rd ? dmem[dm_idx] : '0;
   assign wb_data = ctl.wb_mem ? rdata : alu_result;
   assign dm_we   = !rst && ctl.mem_wr;

   always_ff @(posedge clk) begin
      if (rst && ld_sel == LD_DMEM) dmem[ld_addr[DM_AW-1:0]] <= ld_data;
      else if (dm_we)               dmem[dm_idx] <= rt_val;
   end

   always_ff @(posedge clk) begin
      if (rst && ld_sel == LD_IMEM) imem[ld_addr[IM_AW-1:0]] <= ld_data;
   end

   assign mem_word = dmem[obs_addr];

   // next PC
   assign take    = ctl.branch && zero;
   assign pc_next = take ? pc + (imm_ext << 2) : pc + XLEN'(4);

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   // R1: reset pins the PC at zero
   p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == '0);

   // R2: sequential step when no branch is taken
   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      !(ctl.branch && zero) |=> pc == $past(pc) + XLEN'(4));

   // R3: taken branch lands at own PC plus scaled offset
   p_pc_branch_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl.branch && zero) |=> pc == $past(pc) + ($past(imm_ext) << 2));

   // R4: zero flag on a branch means operands are equal
   p_beq_zero_r4: assert property (@(posedge clk) disable iff (rst)
      ctl.branch |-> (zero == (rs_val == rt_val)));

   // R6: store data lands at the effective address
   p_store_r6: assert property (@(posedge clk) disable iff (rst)
      dm_we |=> dmem[$past(dm_idx)] == $past(rt_val));
endmodule

// File: tb/sim_sc_cpu_core.sv
`timescale 1ns/1ps
module sim_sc_cpu_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  ld_sel = 2'd0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [5:0]  obs_addr = 6'd5;
   logic [31:0] pc, alu_result, mem_word, reg0;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [31:0] m_im [64];
   logic [31:0] m_dm [64];
   logic [31:0] m_rf [32];
   logic [31:0] m_pc;

   always #2.5 clk = ~clk;

   sc_cpu_core u0 (
      .clk(clk), .rst(rst), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
      .obs_addr(obs_addr), .pc(pc), .alu_result(alu_result),
      .mem_word(mem_word), .reg0(reg0)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (pc model %h)", tag, act, exp, m_pc);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic logic [31:0] sx(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   // expected ALU output for an instruction under the model state
   function automatic logic [31:0] exp_alu(input logic [31:0] ins);
      logic [31:0] a, b;
      a = m_rf[ins[25:21]];
      b = m_rf[ins[20:16]];
      case (ins[31:26])
         6'h00: case (ins[5:0])
                   6'h24: return a & b;
                   6'h25: return a | b;
                   6'h22: return a - b;
                   default: return a + b;
                endcase
         6'h23, 6'h2B: return a + sx(ins[15:0]);
         6'h04: return a - b;
         default: return a + b;
      endcase
   endfunction

   function automatic string tag_of(input logic [31:0] ins);
      case (ins[31:26])
         6'h00: return "R5";
         6'h23: return "R7";
         6'h2B: return "R6";
         6'h04: return "R4";
         default: return "R8";
      endcase
   endfunction

   // compare outputs against the model, then advance the model by one instruction
   task automatic check_and_step();
      logic [31:0] ins, y;
      bit tk;
      ins = m_im[m_pc[7:2]];
      y = exp_alu(ins);
      chk("pc R8", pc, m_pc);
      chk({"alu ", tag_of(ins), " R8"}, alu_result, y);
      chk("reg0 R10", reg0, m_rf[0]);
      chk("mem_word R9", mem_word, m_dm[5]);
      tk = 1'b0;
      case (ins[31:26])
         6'h00: m_rf[ins[15:11]] = y;
         6'h23: m_rf[ins[20:16]] = m_dm[y[5:0]];
         6'h2B: m_dm[y[5:0]] = m_rf[ins[20:16]];
         6'h04: tk = (y == 32'd0);
         default: ;
      endcase
      m_pc = tk ? m_pc + (sx(ins[15:0]) << 2) : m_pc + 32'd4;
      @(negedge clk);
      if (tk) chk("branch taken R3", pc, m_pc);
      else    chk("pc step R2", pc, m_pc);
   endtask

   task automatic load_all();
      rst = 1'b1;
      for (int i = 0; i < 64; i++) begin
         ld_sel = 2'd1; ld_addr = 6'(i); ld_data = m_im[i]; @(negedge clk);
      end
      for (int i = 0; i < 64; i++) begin
         ld_sel = 2'd2; ld_addr = 6'(i); ld_data = m_dm[i]; @(negedge clk);
      end
      for (int i = 0; i < 32; i++) begin
         ld_sel = 2'd3; ld_addr = 6'(i); ld_data = m_rf[i]; @(negedge clk);
      end
      ld_sel = 2'd0;
      @(negedge clk);
      chk("reset pc R1", pc, 32'd0);
      chk("loaded reg0 R1", reg0, m_rf[0]);
      chk("loaded word R1", mem_word, m_dm[5]);
      m_pc = 32'd0;
      rst = 1'b0;
   endtask

   task automatic directed(input logic [31:0] r5);
      for (int i = 0; i < 64; i++) m_im[i] = enc_r(6'h24, 6, 6, 6);
      for (int i = 0; i < 64; i++) m_dm[i] = 32'd0;
      for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
      m_rf[2] = 32'hFFFF_FFFF; m_rf[3] = 32'd5; m_rf[4] = 32'd4; m_rf[5] = r5;
      m_im[0]  = enc_r(6'h24, 0, 1, 2);
      m_im[1]  = enc_r(6'h25, 0, 1, 2);
      m_im[2]  = enc_r(6'h20, 0, 3, 4);
      m_im[3]  = enc_r(6'h22, 0, 3, 4);
      m_im[4]  = enc_i(6'h2B, 1, 4, 5);
      m_im[5]  = enc_i(6'h23, 1, 0, 5);
      m_im[6]  = enc_i(6'h04, 3, 5, 2);
      m_im[7]  = enc_r(6'h20, 0, 3, 3);
      m_im[8]  = enc_r(6'h25, 0, 1, 2);
      m_im[9]  = enc_r(6'h24, 0, 1, 2);
      m_im[10] = enc_r(6'h25, 0, 1, 2);
      m_im[11] = enc_r(6'h20, 0, 3, 4);
      m_im[12] = enc_r(6'h22, 0, 3, 4);
      load_all();
      for (int c = 0; c < 14; c++) begin
         if (c == 0) chk("AND result R5", alu_result, 32'd0);
         if (c == 3) chk("ADD into R0 R10", reg0, 32'd9);
         if (c == 5) chk("store of R4 R6", mem_word, 32'd4);
         if (c == 6) chk("load into R0 R7", reg0, 32'd4);
         if (c == 7) chk("branch target R3", pc, (r5 == 32'd5) ? 32'd32 : 32'd28);
         check_and_step();
      end
   endtask

   function automatic logic [31:0] rand_instr();
      int k, a, b, d;
      k = int'($urandom % 8);
      a = int'($urandom % 8); b = int'($urandom % 8); d = int'($urandom % 8);
      case (k)
         0: return enc_r(6'h24, d, a, b);
         1: return enc_r(6'h25, d, a, b);
         2, 3: return enc_r(6'h20, d, a, b);
         4: return enc_r(6'h22, d, a, b);
         5: return enc_i(6'h2B, a, b, int'($urandom % 16) - 8);
         6: return enc_i(6'h23, a, b, int'($urandom % 16) - 8);
         default: return enc_i(6'h04, a, b, int'($urandom % 9) - 4);
      endcase
   endfunction

   task automatic random_round();
      for (int i = 0; i < 64; i++) m_im[i] = rand_instr();
      for (int i = 0; i < 64; i++) m_dm[i] = $urandom;
      for (int i = 0; i < 32; i++) m_rf[i] = ($urandom % 3 == 0) ? 32'(($urandom % 4)) : $urandom;
      load_all();
      for (int c = 0; c < 200; c++) check_and_step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      directed(32'd5);
      directed(32'd6);
      for (int r = 0; r < 10; r++) random_round();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog R8: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule